// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block holds the word address for a pipelined synchronous burst memory. It captures a starting address on either of two active-low address strobes. One strobe comes from a cache or memory controller and the other from a processor. The block then steps the address through a four-beat burst, one beat for each clock edge on which the active-low advance input is low. Only the two least-significant address bits move during a burst. They follow either a linear (count-up, modulo 4) order or an interleaved (start XOR beat) order, chosen when the burst starts.

Three chip enables qualify a start: a main enable (active low), a positive secondary enable and a negative secondary enable. The main enable can mask the processor strobe entirely, but it cannot mask the controller strobe. A strobe that arrives while the chip is not fully selected ends the current cycle. The outputs are the current word address, a cycle-active flag and a write qualifier for the array behind the block. The write qualifier is taken from the write-enable input only when the controller strobe starts a cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it, until the first start, `active` and `is_write` are 0 and `word_addr` is 0.
- R2: On an edge where `strb_cpu_n`=0, `ce_main_n`=0, `ce_pos`=1 and `ce_neg_n`=0, `word_addr` takes `addr_in`, `active` becomes 1 and `is_write` becomes 0. This takes priority over the controller strobe.
- R3: When `ce_main_n`=1, a low `strb_cpu_n` has no effect. With `strb_ctl_n` and `adv_n` both high, the address and `active` hold.
- R4: On an edge where `strb_ctl_n`=0 and `strb_cpu_n`=1 with all three enables true, `word_addr` loads `addr_in`, `active` becomes 1 and `is_write` becomes the inverse of `wr_en_n`. A low `strb_ctl_n` with `strb_cpu_n` also low is not a controller start.
- R5: A start request (R2 or R4 strobe condition) with the chip not fully enabled clears `active` and `is_write` and leaves `word_addr` unchanged.
- R6: With `burst_ilv`=0 latched at the start, the low two bits on beat k are (start + k) mod 4.
- R7: With `burst_ilv`=1 latched at the start, the low two bits on beat k are start XOR k.
- R8: While active, an edge with `adv_n`=1 and no start holds `word_addr`. The next edge with `adv_n`=0 moves on to the following beat.
- R9: After the fourth beat, further advances wrap back to the start address. Bits above the low two never change without a start.
- R10: A start during a burst loads the new address and restarts at beat zero.
- R11: `adv_n` has no effect while `active`=0. `wr_en_n` has no effect except on a controller start. `burst_ilv` has no effect except on a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | Starting word address |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Main chip enable, active low |
| ce_pos | input | 1 | Secondary chip enable, active high |
| ce_neg_n | input | 1 | Secondary chip enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wr_en_n | input | 1 | Write enable, active low |
| word_addr | output | ADDR_W | Current word address |
| active | output | 1 | A burst cycle is in progress |
| is_write | output | 1 | The current cycle is a write |

## Verification
The bench builds the block with an 8-bit address and the default 2-bit beat counter. With these values the whole address fits in one table column, so the bench can check at once that the upper six bits stay put while the lower two walk and wrap. Start values 2 and 1 are chosen so that linear and interleaved orders give visibly different sequences. Every strobe and enable combination in R2 through R5 lands on a distinct, predictable address or flag change.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_STOP = 2'd3
  } seq_cmd_e;
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsq_cmd_decode.sv
module bsq_cmd_decode
  import bsq_pkg::*;
(
  input  logic     strb_ctl_n,
  input  logic     strb_cpu_n,
  input  logic     adv_n,
  input  logic     ce_main_n,
  input  logic     ce_pos,
  input  logic     ce_neg_n,
  input  logic     active,
  output seq_cmd_e cmd,
  output logic     from_ctl
);
  logic selected;
  logic cpu_req;
  logic ctl_req;

  always_comb begin
    selected = !ce_main_n && ce_pos && !ce_neg_n;
    // main enable masks the processor strobe only
    cpu_req  = !strb_cpu_n && !ce_main_n;
    // controller strobe counts only with the processor strobe idle
    ctl_req  = !strb_ctl_n && strb_cpu_n;
    from_ctl = ctl_req && !cpu_req;
    if (cpu_req || ctl_req) begin
      cmd = selected ? CMD_LOAD : CMD_STOP;
    end else if (active && !adv_n) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd,
  output logic [BEAT_W-1:0] beat
);
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = 1'b0;
    beat_d  = beat_q;
    unique case (cmd)
      CMD_LOAD: begin beat_en = 1'b1; beat_d = '0; end
      CMD_STEP: begin beat_en = 1'b1; beat_d = beat_q + 1'b1; end
      default:  begin beat_en = 1'b0; beat_d = beat_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;
endmodule

// File: rtl/bsq_addr_mix.sv
module bsq_addr_mix #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv,
  output logic [ADDR_W-1:0] addr
);
  logic [BEAT_W-1:0] low_lin;
  logic [BEAT_W-1:0] low_ilv;

  always_comb begin
    low_lin = base[BEAT_W-1:0] + beat;
    low_ilv = base[BEAT_W-1:0] ^ beat;
    addr    = {base[ADDR_W-1:BEAT_W], ilv ? low_ilv : low_lin};
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BEAT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_ctl_n,
  input  logic              strb_cpu_n,
  input  logic              adv_n,
  input  logic              ce_main_n,
  input  logic              ce_pos,
  input  logic              ce_neg_n,
  input  logic              burst_ilv,
  input  logic              wr_en_n,
  output logic [ADDR_W-1:0] word_addr,
  output logic              active,
  output logic              is_write
);
  logic              rst_int_n;
  seq_cmd_e          cmd;
  logic              from_ctl;
  logic [BEAT_W-1:0] beat;

  logic [ADDR_W-1:0] base_q, base_d;
  logic              ilv_q, ilv_d;
  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic              load_en;
  logic              flag_en;

  bsq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  bsq_cmd_decode u_dec (
    .strb_ctl_n (strb_ctl_n),
    .strb_cpu_n (strb_cpu_n),
    .adv_n      (adv_n),
    .ce_main_n  (ce_main_n),
    .ce_pos     (ce_pos),
    .ce_neg_n   (ce_neg_n),
    .active     (act_q),
    .cmd        (cmd),
    .from_ctl   (from_ctl)
  );

  bsq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cmd   (cmd),
    .beat  (beat)
  );

  always_comb begin
    load_en = (cmd == CMD_LOAD);
    flag_en = (cmd == CMD_LOAD) || (cmd == CMD_STOP);
    base_d  = addr_in;
    ilv_d   = burst_ilv;
    act_d   = load_en;
    wr_d    = load_en && from_ctl && !wr_en_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (load_en) begin
      base_q <= base_d;
      ilv_q  <= ilv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (flag_en) begin
      act_q <= act_d;
      wr_q  <= wr_d;
    end
  end

  bsq_addr_mix #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_mix (
    .base (base_q),
    .beat (beat),
    .ilv  (ilv_q),
    .addr (word_addr)
  );

  assign active   = act_q;
  assign is_write = wr_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strb_ctl_n,
  input logic              strb_cpu_n,
  input logic              adv_n,
  input logic              ce_main_n,
  input logic              ce_pos,
  input logic              ce_neg_n,
  input logic              wr_en_n,
  input logic [ADDR_W-1:0] word_addr,
  input logic              active,
  input logic              is_write
);
  logic all_en;
  logic ctl_go;
  logic cpu_go;
  assign all_en = !ce_main_n && ce_pos && !ce_neg_n;
  assign ctl_go = !strb_ctl_n && strb_cpu_n;
  assign cpu_go = !strb_cpu_n && !ce_main_n;

  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_go && all_en) |=> (active && !is_write && word_addr == $past(addr_in)));

  assert_main_masks_cpu_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ce_main_n && strb_ctl_n && adv_n) |=> ($stable(word_addr) && $stable(active)));

  assert_ctl_write_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_go && all_en) |=> (active && is_write == !$past(wr_en_n)));

  assert_deselect_ends_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((ctl_go || cpu_go) && !all_en) |=> (!active && !is_write && $stable(word_addr)));

  assert_adv_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_n && strb_ctl_n && strb_cpu_n) |=> $stable(word_addr));

  assert_upper_bits_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (strb_ctl_n && strb_cpu_n) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .addr_in    (addr_in),
  .strb_ctl_n (strb_ctl_n),
  .strb_cpu_n (strb_cpu_n),
  .adv_n      (adv_n),
  .ce_main_n  (ce_main_n),
  .ce_pos     (ce_pos),
  .ce_neg_n   (ce_neg_n),
  .wr_en_n    (wr_en_n),
  .word_addr  (word_addr),
  .active     (active),
  .is_write   (is_write)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 8;
  localparam real CLK_NS = 4.0;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_ctl_n, strb_cpu_n, adv_n;
  logic          ce_main_n, ce_pos, ce_neg_n;
  logic          burst_ilv, wr_en_n;
  logic [AW-1:0] word_addr;
  logic          active, is_write;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_ctl_n(strb_ctl_n), .strb_cpu_n(strb_cpu_n), .adv_n(adv_n),
    .ce_main_n(ce_main_n), .ce_pos(ce_pos), .ce_neg_n(ce_neg_n),
    .burst_ilv(burst_ilv), .wr_en_n(wr_en_n),
    .word_addr(word_addr), .active(active), .is_write(is_write)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  typedef struct packed {
    logic          ctl_n;
    logic          cpu_n;
    logic          adv_n;
    logic          cem_n;
    logic          cep;
    logic          cen_n;
    logic          ilv;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic          e_act;
    logic          e_wr;
    logic [AW-1:0] e_addr;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 24;
  // ctl cpu adv cem cep cen ilv wr addr     act wr exp_addr req
  localparam vec_t TBL [NV] = '{
    '{1,0,1,0,1,0,0,1,8'h46, 1,0,8'h46, 8'd2 },  // R2 processor start, linear
    '{1,1,0,0,1,0,0,1,8'h00, 1,0,8'h47, 8'd6 },  // R6 beat 1
    '{1,1,1,0,1,0,0,1,8'h00, 1,0,8'h47, 8'd8 },  // R8 wait state
    '{1,1,0,0,1,0,0,1,8'h00, 1,0,8'h44, 8'd6 },  // R6 beat 2 wraps low bits
    '{1,1,0,0,1,0,0,1,8'h00, 1,0,8'h45, 8'd6 },  // R6 beat 3
    '{1,1,0,0,1,0,0,1,8'h00, 1,0,8'h46, 8'd9 },  // R9 back to start
    '{0,1,1,0,1,0,1,0,8'h91, 1,1,8'h91, 8'd4 },  // R4 controller write, interleaved
    '{1,1,0,0,1,0,1,1,8'h00, 1,1,8'h90, 8'd7 },  // R7 beat 1
    '{1,1,0,0,1,0,1,1,8'h00, 1,1,8'h93, 8'd7 },  // R7 beat 2
    '{1,1,0,0,1,0,1,1,8'h00, 1,1,8'h92, 8'd7 },  // R7 beat 3
    '{1,1,0,0,1,0,1,1,8'h00, 1,1,8'h91, 8'd9 },  // R9 wrap
    '{1,0,1,1,1,0,0,1,8'h20, 1,1,8'h91, 8'd3 },  // R3 processor strobe masked
    '{0,0,1,1,1,0,0,0,8'h33, 1,1,8'h91, 8'd4 },  // R4 controller with processor low: no start
    '{0,1,1,1,1,0,0,0,8'h33, 0,0,8'h91, 8'd5 },  // R5 controller while deselected
    '{1,1,0,0,1,0,0,1,8'h00, 0,0,8'h91, 8'd11},  // R11 advance while idle
    '{0,1,1,0,1,0,0,1,8'hFE, 1,0,8'hFE, 8'd4 },  // R4 controller read
    '{1,1,0,0,1,0,0,1,8'h00, 1,0,8'hFF, 8'd6 },  // R6 beat 1 from 2
    '{1,0,1,0,1,0,1,1,8'h0B, 1,0,8'h0B, 8'd10},  // R10 restart mid-burst
    '{1,1,0,0,1,0,1,1,8'h00, 1,0,8'h0A, 8'd7 },  // R7 beat 1 from 3
    '{1,0,1,0,0,0,1,1,8'h50, 0,0,8'h0A, 8'd5 },  // R5 positive enable low
    '{1,0,1,0,1,0,1,1,8'h50, 1,0,8'h50, 8'd2 },  // R2 start again
    '{0,1,1,0,1,1,1,1,8'h77, 0,0,8'h50, 8'd5 },  // R5 negative enable high
    '{1,0,1,0,1,0,1,0,8'h61, 1,0,8'h61, 8'd11},  // R11 write enable ignored on processor start
    '{1,1,0,0,1,0,0,0,8'h00, 1,0,8'h60, 8'd11}   // R11 order latched, write enable ignored
  };

  task automatic drive_idle();
    addr_in = '0; strb_ctl_n = 1; strb_cpu_n = 1; adv_n = 1;
    ce_main_n = 0; ce_pos = 1; ce_neg_n = 0; burst_ilv = 0; wr_en_n = 1;
  endtask

  task automatic check(input string tag, input logic a, input logic w,
                       input logic [AW-1:0] ad);
    checks++;
    if (active !== a || is_write !== w || word_addr !== ad) begin
      errors++;
      $display("FAIL %s: got act=%0b wr=%0b addr=%02h, expected act=%0b wr=%0b addr=%02h",
               tag, active, is_write, word_addr, a, w, ad);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 0, 0, '0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after reset", 0, 0, '0);

    for (int i = 0; i < NV; i++) begin
      strb_ctl_n = TBL[i].ctl_n; strb_cpu_n = TBL[i].cpu_n; adv_n = TBL[i].adv_n;
      ce_main_n  = TBL[i].cem_n; ce_pos     = TBL[i].cep;   ce_neg_n = TBL[i].cen_n;
      burst_ilv  = TBL[i].ilv;   wr_en_n    = TBL[i].wr_n;  addr_in  = TBL[i].addr;
      @(posedge clk);
      #1;
      check($sformatf("row %0d R%0d", i, TBL[i].req), TBL[i].e_act, TBL[i].e_wr, TBL[i].e_addr);
    end

    // R8: several wait states, then resume
    drive_idle();
    strb_cpu_n = 0; addr_in = 8'hC1; burst_ilv = 0;
    @(posedge clk); #1;
    drive_idle();
    repeat (3) @(posedge clk);
    #1;
    check("R8 held over three waits", 1, 0, 8'hC1);
    adv_n = 0;
    @(posedge clk); #1;
    check("R8 resumed beat 1", 1, 0, 8'hC2);

    // R9: eight advances return to start, upper bits untouched
    repeat (7) @(posedge clk);
    #1;
    check("R9 two full laps", 1, 0, 8'hC1);

    // R1: asynchronous reset mid-burst
    adv_n = 1;
    #1 rst_n = 0;
    #1;
    check("R1 async clear", 0, 0, '0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 idle after re-release", 0, 0, '0);

    finish_run();
  end
endmodule